// File: doc/BRIEF.md
# Serial Memory Slave Controller

This block is the pin-side controller of a serial-bus non-volatile memory that uses clock mode 0. It samples chip select, serial clock, serial data in, write protect and hold on its own system clock. It decodes an 8-bit instruction, a 16-bit address and a stream of data bytes, all MSB first. It answers reads from a cell array and reports a status byte. For writes it waits for chip select to rise, then launches a timed internal write cycle.

The cell array is a reset-cleared register array of `DEPTH` bytes, addressed by the low address bits. A write cycle takes `WR_CYCLES` system clocks. A status bit decides whether the protect pin can block status writes. Hold freezes a transfer and resumes it later; both steps depend on the serial clock level.

The sequencer uses the states IDLE, OPCODE, ADDR, WDATA, SWDATA, RDATA, SDATA and IGNORE:
- A falling chip select moves any state to OPCODE.
- A rising chip select moves any state to IDLE.
- On the eighth clock rise, OPCODE moves to ADDR (read or write), SWDATA (write status), SDATA (read status), or IGNORE (write enable, write disable, a refused or unknown opcode, or anything other than read status while busy).
- On the sixteenth rise, ADDR moves to RDATA for a read or WDATA for a write.
- WDATA, SWDATA, RDATA, SDATA and IGNORE stay put until chip select rises.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, so_oe is 0, the status byte reads 0x00 and every cell reads 0x00.
- R2: A transfer starts only on a high-to-low chip-select edge seen after reset. A selection already active when reset ends is ignored until chip select has gone high. While chip select is high, so_oe is 0 at once.
- R3: si is sampled on sck rising edges, MSB first. so changes only on sck falling edges, so the master samples so on the next rise.
- R4: A write is opcode 0x02, a 16-bit address and one or more data bytes. It is valid only if the write-enable latch is set and chip select rises right after a complete byte. The last complete byte is then stored at address mod DEPTH. A write that is not valid stores nothing.
- R5: A valid write sets status bit 0 (busy) for WR_CYCLES clocks whether chip select is high or low. The new data becomes visible only once busy clears.
- R6: Status bit 1 (write-enable latch) is set by opcode 0x06 and cleared by opcode 0x04. It is also cleared when a write cycle completes.
- R7: While busy, every opcode except read status (0x05) is ignored: a read drives nothing and a write enable has no effect.
- R8: Opcode 0x05 returns the status byte repeatedly: bit 7 is the protect-enable flag, bit 1 the write-enable latch, bit 0 busy, and the other bits are 0. Opcode 0x01 followed by one byte writes only bit 7, through a timed write cycle.
- R9: If the protect-enable flag is 1 and wp_n is low at any time while a status write is selected, that write is dropped: no busy, and the latch is kept. If the flag is 0, wp_n is ignored. Data writes never depend on wp_n.
- R10: Hold takes effect when hold_n is low while sck is low; if sck is high it waits for the next sck fall. While paused, so_oe is 0 and sck and si are ignored. The transfer resumes only when hold_n rises while sck is low.
- R11: Opcode 0x03 plus an address streams bytes from that address, incrementing and wrapping modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Status write protect, active low |
| hold_n | input | 1 | Transfer pause, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |

## Verification
The assertions assume the pins are already synchronous to clk. They also assume sck is stable for at least one clk period around every chip-select edge, so that a select edge never coincides with a clock edge. The stimulus keeps to this by changing pins only on falling clk edges. It holds each sck level for four clk periods and moves chip select only while sck is low.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPCODE, ST_ADDR, ST_WDATA,
        ST_SWDATA, ST_RDATA, ST_SDATA, ST_IGNORE
    } sm_state_t;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;

    function automatic sm_state_t decode_op(input logic [7:0] op,
                                            input logic busy,
                                            input logic wel);
        sm_state_t nxt;
        nxt = ST_IGNORE;
        if (!busy || op == OP_RDSR) begin
            case (op)
                OP_READ:  nxt = ST_ADDR;
                OP_WRITE: nxt = wel ? ST_ADDR : ST_IGNORE;
                OP_WRSR:  nxt = wel ? ST_SWDATA : ST_IGNORE;
                OP_RDSR:  nxt = ST_SDATA;
                default:  nxt = ST_IGNORE;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/spi_cell_array.sv
module spi_cell_array #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spi_write_timer.sv
module spi_write_timer #(
    parameter int CYCLES = 1000,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                cnt  <= CW'(CYCLES - 1);
            end else if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R5
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int WR_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    localparam int IDX_W     = $clog2(DEPTH);
    localparam int ADDR_BITS = 16;

    sm_state_t state, state_d;
    logic cs_n_q, sck_q, hold_q, paused;
    logic [3:0] bcnt;
    logic [6:0] sh;
    logic op_is_read;
    logic [ADDR_BITS-1:0] addr;
    logic [7:0] wbyte;
    logic have_byte;
    logic [2:0] obit;
    logic so_q, wel, wpen, wp_low_seen;
    logic [IDX_W-1:0] pend_addr;
    logic [7:0] pend_data;
    logic pend_status;

    logic cs_rise, cs_fall, selected, sck_rise, sck_fall;
    logic [7:0] in_byte, status, rd_data;
    logic prot, wr_start, wr_busy, wr_done, mem_we;

    assign cs_rise  = cs_n & ~cs_n_q;
    assign cs_fall  = ~cs_n & cs_n_q;
    assign selected = ~cs_n & ~cs_n_q & (state != ST_IDLE) & ~paused;
    assign sck_rise = selected & sck & ~sck_q;
    assign sck_fall = selected & ~sck & sck_q;
    assign in_byte  = {sh, si};
    assign status   = {wpen, 5'b0, wel, wr_busy};
    assign prot     = wpen & (wp_low_seen | ~wp_n);
    assign wr_start = cs_rise & ~wr_busy & have_byte & (bcnt == 4'd0) &
                      ((state == ST_WDATA) | ((state == ST_SWDATA) & ~prot));
    assign mem_we   = wr_done & ~pend_status;

    spi_write_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(wr_start),
        .busy(wr_busy), .done(wr_done)
    );

    spi_cell_array #(.DEPTH(DEPTH), .DW(8)) u_cells (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(pend_addr),
        .wdata(pend_data), .raddr(addr[IDX_W-1:0]), .rdata(rd_data)
    );

    // next-state logic
    always_comb begin
        state_d = state;
        if (cs_rise) begin
            state_d = ST_IDLE;
        end else if (cs_fall) begin
            state_d = ST_OPCODE;
        end else if (sck_rise) begin
            unique case (state)
                ST_OPCODE: if (bcnt == 4'd7) state_d = decode_op(in_byte, wr_busy, wel);
                ST_ADDR:   if (bcnt == 4'd15) state_d = op_is_read ? ST_RDATA : ST_WDATA;
                default:   state_d = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q <= 1'b0;  sck_q <= 1'b0;  hold_q <= 1'b1;  paused <= 1'b0;
            bcnt <= '0;  sh <= '0;  op_is_read <= 1'b0;  addr <= '0;
            wbyte <= '0;  have_byte <= 1'b0;  obit <= '0;  so_q <= 1'b0;
            wel <= 1'b0;  wpen <= 1'b0;  wp_low_seen <= 1'b0;
            pend_addr <= '0;  pend_data <= '0;  pend_status <= 1'b0;
        end else begin
            cs_n_q <= cs_n;
            sck_q  <= sck;
            hold_q <= hold_n;

            if (cs_n || state == ST_IDLE)                 paused <= 1'b0;
            else if (!paused && !hold_n && !sck)          paused <= 1'b1;
            else if (paused && hold_n && !hold_q && !sck) paused <= 1'b0;

            if (cs_fall)                                wp_low_seen <= 1'b0;
            else if (state != ST_IDLE && !wp_n)         wp_low_seen <= 1'b1;

            if (cs_fall) begin
                bcnt <= '0;  have_byte <= 1'b0;  obit <= '0;
            end else if (sck_rise) begin
                sh <= in_byte[6:0];
                unique case (state)
                    ST_OPCODE: begin
                        if (bcnt == 4'd7) begin
                            bcnt       <= '0;
                            op_is_read <= (in_byte == OP_READ);
                            if (!wr_busy && in_byte == OP_WREN) wel <= 1'b1;
                            if (!wr_busy && in_byte == OP_WRDI) wel <= 1'b0;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        addr <= {addr[ADDR_BITS-2:0], si};
                        bcnt <= bcnt + 1'b1;
                    end
                    ST_WDATA, ST_SWDATA: begin
                        if (bcnt == 4'd7) begin
                            wbyte     <= in_byte;
                            have_byte <= 1'b1;
                            bcnt      <= '0;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (sck_fall) begin
                unique case (state)
                    ST_RDATA: begin
                        so_q <= rd_data[~obit];
                        if (obit == 3'd7) addr <= addr + 1'b1;
                        obit <= obit + 1'b1;
                    end
                    ST_SDATA: begin
                        so_q <= status[~obit];
                        obit <= obit + 1'b1;
                    end
                    default: ;
                endcase
            end

            if (wr_start) begin
                pend_addr   <= addr[IDX_W-1:0];
                pend_data   <= wbyte;
                pend_status <= (state == ST_SWDATA);
            end
            if (wr_done) begin
                wel <= 1'b0;
                if (pend_status) wpen <= pend_data[7];
            end
        end
    end

    assign so    = so_q;
    assign so_oe = ~cs_n & ~paused & ((state == ST_RDATA) | (state == ST_SDATA));

    // R4
    start_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> cs_n_q);
    // R6
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_busy) |=> !wel);
    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> !(state inside {ST_ADDR, ST_WDATA, ST_SWDATA, ST_RDATA}));
    // R10
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !cs_n) |=> $stable(bcnt));
endmodule

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;
    localparam int DEPTH = 16;
    localparam int WRC   = 2000;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, si = 1'b0;
    logic wp_n = 1'b1, hold_n = 1'b1;
    logic so, so_oe;
    int total = 0, bad = 0;
    bit finished = 1'b0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    spi_mem_slave #(.DEPTH(DEPTH), .WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .wp_n(wp_n), .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic r);
        si = b;  waitc(4);  r = so;
        sck = 1'b1;  waitc(4);  sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            sbit(tx[i], b);
            rx[i] = b;
        end
    endtask

    task automatic sel;
        waitc(2);  cs_n = 1'b0;  waitc(4);
    endtask

    task automatic desel;
        waitc(4);  cs_n = 1'b1;  waitc(6);
    endtask

    task automatic send(input logic [7:0] op);
        logic [7:0] d;
        sel;  xfer(op, d);  desel;
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel;  xfer(8'h05, d);  xfer(8'h00, s);  desel;
    endtask

    task automatic wait_idle;
        logic [7:0] s;
        for (int i = 0; i < 60; i++) begin
            rdsr(s);
            if (!s[0]) return;
        end
        chk("R5 busy never cleared", 32'(s[0]), 0);
    endtask

    task automatic write_start(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] d;
        send(8'h06);
        sel;  xfer(8'h02, d);  xfer(a[15:8], d);  xfer(a[7:0], d);  xfer(v, d);  desel;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;  bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, d;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        waitc(5);
        rst_n = 1'b1;
        waitc(2);
        chk("R1 so_oe after reset", 32'(so_oe), 0);

        // R2: chip select low across reset: write enable must be ignored
        xfer(8'h06, d);
        desel;
        rdsr(s);
        chk("R2 selection at reset ignored / R1 status", 32'(s), 0);

        // R6 latch set and clear
        send(8'h06);  rdsr(s);  chk("R6 wren sets bit1", 32'(s), 32'h02);
        send(8'h04);  rdsr(s);  chk("R6 wrdi clears bit1", 32'(s), 32'h00);

        // R4 write without latch stores nothing
        sel;  xfer(8'h02, d);  xfer(8'h00, d);  xfer(8'h08, d);  xfer(8'h77, d);  desel;
        rdsr(s);  chk("R4 no latch no busy", 32'(s), 0);

        // R4/R5 sweep all cells, high address bits vary
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] v;
            v = 8'((a * 29 + 7) & 8'hFF);
            write_start({8'(a * 16 + 3), 8'(a)}, v);
            rdsr(s);  chk("R5 busy and latch set during cycle", 32'(s), 32'h03);
            wait_idle;
            rdsr(s);  chk("R6 latch cleared after cycle", 32'(s), 0);
            model[a] = v;
        end

        // R7 busy ignores read and write enable
        write_start(16'h0002, 8'h5A);
        sel;  xfer(8'h03, d);  xfer(8'h00, d);  xfer(8'h02, d);  xfer(8'h00, d);
        chk("R7 read while busy drives nothing", 32'(so_oe), 0);
        desel;
        send(8'h06);
        wait_idle;
        rdsr(s);  chk("R7 wren while busy ignored", 32'(s), 0);
        model[2] = 8'h5A;

        // R4 incomplete byte: no cycle, latch kept
        send(8'h06);
        sel;  xfer(8'h02, d);  xfer(8'h00, d);  xfer(8'h07, d);
        for (int i = 0; i < 4; i++) begin
            logic b;
            sbit(1'b1, b);
        end
        desel;
        rdsr(s);  chk("R4 partial byte rejected", 32'(s), 32'h02);
        send(8'h04);

        // R4 multi-byte: last byte kept
        send(8'h06);
        sel;  xfer(8'h02, d);  xfer(8'h00, d);  xfer(8'h09, d);
        xfer(8'h11, d);  xfer(8'h22, d);  xfer(8'h33, d);  desel;
        wait_idle;
        model[9] = 8'h33;

        // R9 protect flag 0: pin ignored
        wp_n = 1'b0;
        send(8'h06);
        sel;  xfer(8'h01, d);  xfer(8'h80, d);  desel;
        wait_idle;
        rdsr(s);  chk("R9 pin ignored when flag clear / R8 bit7", 32'(s), 32'h80);

        // R9 flag 1, pin low: status write dropped
        send(8'h06);
        sel;  xfer(8'h01, d);  xfer(8'h00, d);  desel;
        rdsr(s);  chk("R9 protected status write dropped", 32'(s), 32'h82);
        send(8'h04);

        // R9 pin drops mid-sequence
        wp_n = 1'b1;
        send(8'h06);
        sel;  xfer(8'h01, d);  wp_n = 1'b0;  waitc(3);  wp_n = 1'b1;  xfer(8'h00, d);  desel;
        rdsr(s);  chk("R9 mid-sequence drop cancels", 32'(s), 32'h82);
        send(8'h04);

        // R9 data write unaffected by pin
        wp_n = 1'b0;
        write_start(16'h0003, 8'hAA);
        wait_idle;
        model[3] = 8'hAA;

        // R8 status write allowed with pin high, status repeats
        wp_n = 1'b1;
        send(8'h06);
        sel;  xfer(8'h01, d);  xfer(8'h00, d);  desel;
        wait_idle;
        sel;  xfer(8'h05, d);  xfer(8'h00, s);  xfer(8'h00, d);  desel;
        chk("R8 status cleared", 32'(s), 0);
        chk("R8 status repeats", 32'(d), 0);

        // R11/R3 burst read with wrap
        sel;  xfer(8'h03, d);  xfer(8'hFF, d);  xfer(8'h0C, d);
        for (int i = 0; i < 20; i++) begin
            xfer(8'h00, d);
            chk("R11 burst byte", 32'(d), 32'(model[(12 + i) % DEPTH]));
        end
        desel;

        // R2 chip select high kills output at once
        sel;  xfer(8'h03, d);  xfer(8'h00, d);  xfer(8'h00, d);  xfer(8'h00, d);
        chk("R3 read output enabled", 32'(so_oe), 1);
        @(negedge clk);  cs_n = 1'b1;  #1;
        chk("R2 deselect drops so_oe", 32'(so_oe), 0);
        waitc(6);

        // R10 hold during read data
        sel;  xfer(8'h03, d);  xfer(8'h00, d);  xfer(8'h05, d);  xfer(8'h00, d);
        chk("R10 byte before pause", 32'(d), 32'(model[5]));
        hold_n = 1'b0;  waitc(3);
        chk("R10 paused so_oe", 32'(so_oe), 0);
        for (int i = 0; i < 3; i++) begin
            si = 1'(i);  sck = 1'b1;  waitc(3);  sck = 1'b0;  waitc(3);
        end
        hold_n = 1'b1;  waitc(3);
        chk("R10 resumed so_oe", 32'(so_oe), 1);
        xfer(8'h00, d);
        chk("R10 byte after pause", 32'(d), 32'(model[6]));
        desel;

        // R10 hold inside address field
        sel;  xfer(8'h03, d);  xfer(8'h00, d);
        for (int i = 7; i >= 4; i--) begin
            logic b;
            sbit(d[0] & 1'b0, b);
        end
        hold_n = 1'b0;  waitc(3);
        for (int i = 0; i < 4; i++) begin
            si = 1'b1;  sck = 1'b1;  waitc(3);  sck = 1'b0;  waitc(3);
        end
        hold_n = 1'b1;  waitc(3);
        for (int i = 3; i >= 0; i--) begin
            logic b;
            sbit(i != 2, b);
        end
        xfer(8'h00, d);
        chk("R10 address intact after pause", 32'(d), 32'(model[11]));

        // R10 hold asserted while sck high waits for fall; rise with sck high does not resume
        si = 1'b0;  waitc(4);  sck = 1'b1;  waitc(2);  hold_n = 1'b0;  waitc(3);
        chk("R10 not paused while sck high", 32'(so_oe), 1);
        sck = 1'b0;  waitc(3);
        chk("R10 paused after fall", 32'(so_oe), 0);
        sck = 1'b1;  waitc(2);  hold_n = 1'b1;  waitc(3);  sck = 1'b0;  waitc(3);
        chk("R10 no resume with sck high", 32'(so_oe), 0);
        desel;

        // R1 final status
        rdsr(s);  chk("R8 final status", 32'(s), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule